// File: doc/BRIEF.md
# Pixel Component Packer and Serializer

This block sits between a pixel stream and a memory transfer channel. On the write path it takes one pixel made of several components of equal bit width and turns it into memory transfer words. On the read path it takes transfer words and rebuilds the same pixels. Both paths use valid/ready handshakes on both sides.

A build-time switch `PACKED` selects one of two layouts.

- **Packed layout:** every component of a pixel is placed side by side in one transfer word. The word is zero-padded up to the next power of two, and is never narrower than 8 bits. For example, three 10-bit components fill a 32-bit word with 2 zero bits on top. Three 8-bit components fill a 32-bit word with 8 zero bits on top. Four 32-bit components fill one 128-bit word.
- **Unpacked layout:** each component is zero-extended to its own container and sent as a separate transfer on successive handshakes. The container is the next power of two, with a minimum of 8 bits. So 10-bit components travel in 16-bit words, 8-bit components stay 8 bits, and 32-bit components stay 32 bits.

The read path undoes whichever layout was chosen. Words from the write path fed straight into the read path therefore give back the original pixels. The flattened pixel must not be wider than 512 bits; a wider setting stops elaboration.

Top module: `pix_pack_serdes`

## Requirements
- R1: In the packed layout the word width is the smallest power of two that is at least 8 and at least NUM_COMP*COMP_W. All word bits above the pixel are zero.
- R2: In the packed layout `wrData` carries component k in bits [k*COMP_W +: COMP_W]. `wrValid` follows `pixValid` and `pixReady` follows `wrReady` in the same cycle, so each pixel gives exactly one transfer.
- R3: In the unpacked layout the word width is the smallest power of two that is at least 8 and at least COMP_W. Each component sits in bits [COMP_W-1:0] of its word, and every bit above it is zero.
- R4: In the unpacked layout the components of an accepted pixel leave in index order: component 0 (pixel bits [COMP_W-1:0]) first, then one more per accepted transfer. `wrValid` rises in the cycle after the pixel is accepted.
- R5: In the unpacked layout `pixReady` is low while a pixel still has components to send. It is high when the block is idle, and high in the cycle in which the last component is accepted.
- R6: While `wrValid` is high and `wrReady` is low, `wrValid` stays high and `wrData` does not change in the next cycle.
- R7: In the unpacked layout the read path takes bits [COMP_W-1:0] of successive words as components 0, 1, 2 and so on. `outValid` rises in the cycle after the last component is accepted. `rdReady` is low only while a completed pixel waits with `outReady` low.
- R8: In the packed layout `outData` is `rdData[NUM_COMP*COMP_W-1:0]`, `outValid` follows `rdValid`, and `rdReady` follows `outReady`, all in the same cycle.
- R9: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change in the next cycle.
- R10: Words taken from `wrData` and given in the same order to `rdData` return every pixel unchanged and in its original order, in both layouts.
- R11: During and right after reset, `wrValid` and `outValid` are low and `pixReady` is high when `wrReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Pixel to write is valid |
| pixReady | output | 1 | Block accepts the pixel |
| pixData | input | NUM_COMP*COMP_W | Pixel to write, component k at bits [k*COMP_W +: COMP_W] |
| wrValid | output | 1 | Transfer word is valid |
| wrReady | input | 1 | Memory side accepts the word |
| wrData | output | WORD_W | Transfer word toward memory |
| rdValid | input | 1 | Word from memory is valid |
| rdReady | output | 1 | Block accepts the word |
| rdData | input | WORD_W | Transfer word from memory |
| outValid | output | 1 | Rebuilt pixel is valid |
| outReady | input | 1 | Consumer accepts the pixel |
| outData | output | NUM_COMP*COMP_W | Rebuilt pixel |

## Verification
In the packed layout the write and read results appear in the same cycle as their inputs, with no registers in between. In the unpacked layout the first component word appears one cycle after the pixel is accepted, the next word appears one cycle after each word handshake, and a rebuilt pixel appears one cycle after the handshake of its last component.

The bench drives inputs one time unit after the rising edge. At every falling edge it compares each output with a behavioural model that has moved forward by exactly those handshakes, so every result is checked in the cycle it is due. The words captured from the write side are replayed into the read side, and each rebuilt pixel is compared with the pixel queue.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;

  // smallest power of two that is >= w and >= 8
  function automatic int nextPow2(input int w);
    int p;
    p = 8;
    while (p < w) p = p * 2;
    return p;
  endfunction

  function automatic int wordWidth(input int numComp, input int compW, input bit packed_);
    return packed_ ? nextPow2(numComp * compW) : nextPow2(compW);
  endfunction

  // component indices: a pixel holds at most 512 bits, so at most 512 components
  typedef logic [9:0] compIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadPix;  // capture the incoming pixel
    compIdx_t wrIdx;    // component currently presented on wrData
    logic     rdLoad;   // store rdData into slot rdIdx
    compIdx_t rdIdx;    // slot being filled on the read path
  } packStrb_t;

endpackage

// File: rtl/pix_pack_ctrl.sv
module pix_pack_ctrl
  import pix_pack_pkg::*;
#(
  parameter int NUM_COMP = 3,
  parameter bit PACKED   = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pixValid,
  output logic      pixReady,
  output logic      wrValid,
  input  logic      wrReady,
  input  logic      rdValid,
  output logic      rdReady,
  output logic      outValid,
  input  logic      outReady,
  output packStrb_t strb
);

  localparam compIdx_t LAST_IDX = compIdx_t'(NUM_COMP - 1);

  generate
    if (PACKED) begin : g_pass
      // one word per pixel: handshakes pass straight through
      assign wrValid  = pixValid;
      assign pixReady = wrReady;
      assign outValid = rdValid;
      assign rdReady  = outReady;
      assign strb     = '0;
      logic unusedCtrl;
      assign unusedCtrl = clk ^ rstN;
    end else begin : g_ser
      logic     busy;
      compIdx_t wIdx;
      logic     outFull;
      compIdx_t rIdx;
      logic     wrHs, pixHs, rdHs;

      // write side: serialize one component per accepted transfer
      assign wrValid  = busy;
      assign wrHs     = busy && wrReady;
      assign pixReady = !busy || (wrReady && wIdx == LAST_IDX);
      assign pixHs    = pixValid && pixReady;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          busy <= 1'b0;
          wIdx <= '0;
        end else if (pixHs) begin
          busy <= 1'b1;
          wIdx <= '0;
        end else if (wrHs) begin
          if (wIdx == LAST_IDX) begin
            busy <= 1'b0;
            wIdx <= '0;
          end else begin
            wIdx <= wIdx + 1'b1;
          end
        end
      end

      // read side: gather components into slots
      assign outValid = outFull;
      assign rdReady  = !outFull || outReady;
      assign rdHs     = rdValid && rdReady;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outFull <= 1'b0;
          rIdx    <= '0;
        end else begin
          outFull <= (outFull && !outReady) || (rdHs && rIdx == LAST_IDX);
          if (rdHs) rIdx <= (rIdx == LAST_IDX) ? '0 : rIdx + 1'b1;
        end
      end

      assign strb.loadPix = pixHs;
      assign strb.wrIdx   = wIdx;
      assign strb.rdLoad  = rdHs;
      assign strb.rdIdx   = rIdx;

      AST_FIRST_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        pixHs |=> (wrValid && wIdx == '0)); // R4
      AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
        (wIdx <= LAST_IDX) && (rIdx <= LAST_IDX)); // R4
      AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
        (rdHs && rIdx == LAST_IDX) |=> outValid); // R7
      AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
        (wrValid && !wrReady) |-> !pixReady); // R5
    end
  endgenerate

endmodule

// File: rtl/pix_pack_dp.sv
module pix_pack_dp
  import pix_pack_pkg::*;
#(
  parameter int NUM_COMP = 3,
  parameter int COMP_W   = 10,
  parameter bit PACKED   = 1'b0,
  localparam int FLAT_W  = NUM_COMP * COMP_W,
  localparam int WORD_W  = wordWidth(NUM_COMP, COMP_W, PACKED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAT_W-1:0] pixData,
  output logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] rdData,
  output logic [FLAT_W-1:0] outData,
  input  packStrb_t         strb
);

  localparam int IDX_W = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1;

  generate
    if (PACKED) begin : g_wide
      always_comb begin
        wrData             = '0;
        wrData[FLAT_W-1:0] = pixData;
      end
      assign outData = rdData[FLAT_W-1:0];

      logic unusedDp;
      if (WORD_W > FLAT_W) begin : g_pad
        assign unusedDp = ^{clk, rstN, strb, rdData[WORD_W-1:FLAT_W]};
      end else begin : g_nopad
        assign unusedDp = ^{clk, rstN, strb};
      end
    end else begin : g_narrow
      logic [NUM_COMP-1:0][COMP_W-1:0] pixReg;
      logic [NUM_COMP-1:0][COMP_W-1:0] asmReg;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pixReg <= '0;
        else if (strb.loadPix) pixReg <= pixData;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) asmReg <= '0;
        else if (strb.rdLoad) asmReg[strb.rdIdx[IDX_W-1:0]] <= rdData[COMP_W-1:0];
      end

      always_comb begin
        wrData             = '0;
        wrData[COMP_W-1:0] = pixReg[strb.wrIdx[IDX_W-1:0]];
      end
      assign outData = asmReg;

      logic unusedDp;
      if (WORD_W > COMP_W) begin : g_pad
        assign unusedDp = ^{strb.wrIdx[9:IDX_W], strb.rdIdx[9:IDX_W], rdData[WORD_W-1:COMP_W]};
      end else begin : g_nopad
        assign unusedDp = ^{strb.wrIdx[9:IDX_W], strb.rdIdx[9:IDX_W]};
      end
    end
  endgenerate

endmodule

// File: rtl/pix_pack_serdes.sv
module pix_pack_serdes
  import pix_pack_pkg::*;
#(
  parameter int NUM_COMP = 3,
  parameter int COMP_W   = 10,
  parameter bit PACKED   = 1'b0,
  localparam int FLAT_W  = NUM_COMP * COMP_W,
  localparam int WORD_W  = wordWidth(NUM_COMP, COMP_W, PACKED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  output logic              pixReady,
  input  logic [FLAT_W-1:0] pixData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [WORD_W-1:0] wrData,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [WORD_W-1:0] rdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [FLAT_W-1:0] outData
);

  generate
    if (FLAT_W > 512 || NUM_COMP < 1 || COMP_W < 1) begin : g_badCfg
      $error("pix_pack_serdes: pixel must be 1 to 512 bits wide");
    end
  endgenerate

  packStrb_t strb;

  pix_pack_ctrl #(.NUM_COMP(NUM_COMP), .PACKED(PACKED)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pixValid(pixValid), .pixReady(pixReady),
    .wrValid(wrValid), .wrReady(wrReady),
    .rdValid(rdValid), .rdReady(rdReady),
    .outValid(outValid), .outReady(outReady),
    .strb(strb)
  );

  pix_pack_dp #(.NUM_COMP(NUM_COMP), .COMP_W(COMP_W), .PACKED(PACKED)) u_dp (
    .clk(clk), .rstN(rstN),
    .pixData(pixData), .wrData(wrData),
    .rdData(rdData), .outData(outData),
    .strb(strb)
  );

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady && pixValid && $stable(pixData)) |=> (wrValid && $stable(wrData))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && rdValid && $stable(rdData)) |=> (outValid && $stable(outData))); // R9

endmodule

// File: tb/pix_pack_serdes_test.sv
module pix_pack_serdes_lane #(
  parameter int NUM_COMP = 3,
  parameter int COMP_W   = 10,
  parameter bit PACKED   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic drain,
  input  logic endPhase,
  output int   nChecks,
  output int   nFails
);

  function automatic int pow2AtLeast(input int w);
    int p;
    p = 8;
    while (p < w) p = p * 2;
    return p;
  endfunction

  localparam int FLAT_W = NUM_COMP * COMP_W;
  localparam int WORD_W = PACKED ? pow2AtLeast(FLAT_W) : pow2AtLeast(COMP_W);

  logic              pixValid = 1'b0, pixReady;
  logic [FLAT_W-1:0] pixData  = '0;
  logic              wrValid, wrReady = 1'b0;
  logic [WORD_W-1:0] wrData;
  logic              rdValid  = 1'b0, rdReady;
  logic [WORD_W-1:0] rdData   = '0;
  logic              outValid, outReady = 1'b0;
  logic [FLAT_W-1:0] outData;

  pix_pack_serdes #(.NUM_COMP(NUM_COMP), .COMP_W(COMP_W), .PACKED(PACKED)) uut (
    .clk(clk), .rstN(rstN),
    .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  logic [WORD_W-1:0] wordQ[$];
  logic [FLAT_W-1:0] pixQ[$];
  bit pixHsSeen = 0, rdHsSeen = 0;

  // behavioural model state for the unpacked layout
  bit                busyM = 0;
  int                idxM  = 0;
  logic [FLAT_W-1:0] heldM = '0;
  bit                fullM = 0;
  int                rIdxM = 0;
  logic [FLAT_W-1:0] asmM  = '0;
  bit                wrStallPrev = 0, outStallPrev = 0;
  bit                rstChecked = 0, endChecked = 0;

  initial begin
    nChecks = 0;
    nFails  = 0;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s packed=%0d %s: actual %h expected %h", tag, PACKED, what, act, exp);
    end
  endtask

  // stimulus, one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (!(pixValid && !pixHsSeen)) begin
          if (!drain && ($urandom % 3 != 0)) begin
            pixValid = 1'b1;
            pixData  = FLAT_W'({$urandom, $urandom});
          end else begin
            pixValid = 1'b0;
          end
        end
        if (!(rdValid && !rdHsSeen)) begin
          if (wordQ.size() > 0 && (drain || $urandom % 4 != 0)) begin
            rdValid = 1'b1;
            rdData  = wordQ[0];
          end else begin
            rdValid = 1'b0;
          end
        end
        wrReady  = drain ? 1'b1 : ($urandom % 3 != 0);
        outReady = drain ? 1'b1 : ($urandom % 3 != 0);
      end
    end
  end

  logic              eWrValid, ePixReady, eRdReady, eOutValid;
  logic [WORD_W-1:0] eWrData;
  logic [FLAT_W-1:0] eOutData;

  always @(negedge clk) begin
    if (!rstN) begin
      if (!rstChecked) begin
        rstChecked <= 1;
        check(wrValid == 1'b0, "R11", "wrValid in reset", 512'(wrValid), 512'(0));
        check(outValid == 1'b0, "R11", "outValid in reset", 512'(outValid), 512'(0));
        check(pixReady == wrReady || !PACKED, "R11", "pixReady in reset (packed)", 512'(pixReady), 512'(wrReady));
        if (!PACKED) check(pixReady == 1'b1, "R11", "pixReady in reset", 512'(pixReady), 512'(1));
      end
    end else begin
      // expected outputs for this cycle
      if (PACKED) begin
        eWrValid  = pixValid;
        ePixReady = wrReady;
        eWrData   = WORD_W'(pixData);
        eRdReady  = outReady;
        eOutValid = rdValid;
        eOutData  = rdData[FLAT_W-1:0];
      end else begin
        eWrValid  = busyM;
        ePixReady = !busyM || (idxM == NUM_COMP - 1 && wrReady);
        eWrData   = WORD_W'(heldM[idxM*COMP_W +: COMP_W]);
        eRdReady  = !fullM || outReady;
        eOutValid = fullM;
        eOutData  = asmM;
      end

      check(wrValid == eWrValid, PACKED ? "R2" : "R4", "wrValid", 512'(wrValid), 512'(eWrValid));
      check(pixReady == ePixReady, PACKED ? "R2" : "R5", "pixReady", 512'(pixReady), 512'(ePixReady));
      if (eWrValid)
        check(wrData == eWrData, wrStallPrev ? "R6" : (PACKED ? "R1" : "R3"), "wrData",
              512'(wrData), 512'(eWrData));
      check(rdReady == eRdReady, PACKED ? "R8" : "R7", "rdReady", 512'(rdReady), 512'(eRdReady));
      check(outValid == eOutValid, PACKED ? "R8" : "R7", "outValid", 512'(outValid), 512'(eOutValid));
      if (eOutValid)
        check(outData == eOutData, outStallPrev ? "R9" : (PACKED ? "R8" : "R7"), "outData",
              512'(outData), 512'(eOutData));

      // handshakes at the coming edge
      pixHsSeen    <= pixValid && pixReady;
      rdHsSeen     <= rdValid && rdReady;
      wrStallPrev  <= wrValid && !wrReady;
      outStallPrev <= outValid && !outReady;
      if (wrValid && wrReady) wordQ.push_back(wrData);
      if (pixValid && pixReady) pixQ.push_back(pixData);
      if (rdValid && rdReady && wordQ.size() > 0) void'(wordQ.pop_front());
      if (outValid && outReady) begin
        if (pixQ.size() == 0)
          check(1'b0, "R10", "pixel with none expected", 512'(outData), 512'(0));
        else
          check(outData == pixQ[0], "R10", "loopback pixel", 512'(outData), 512'(pixQ[0]));
        if (pixQ.size() > 0) void'(pixQ.pop_front());
      end

      // advance the unpacked model
      if (!PACKED) begin
        if (busyM && wrReady) begin
          if (idxM == NUM_COMP - 1) begin
            busyM = 0;
            idxM  = 0;
          end else begin
            idxM++;
          end
        end
        if (pixValid && ePixReady) begin
          heldM = pixData;
          busyM = 1;
          idxM  = 0;
        end
        if (fullM && outReady) fullM = 0;
        if (rdValid && eRdReady) begin
          asmM[rIdxM*COMP_W +: COMP_W] = rdData[COMP_W-1:0];
          if (rIdxM == NUM_COMP - 1) begin
            fullM = 1;
            rIdxM = 0;
          end else begin
            rIdxM++;
          end
        end
      end

      if (endPhase && !endChecked) begin
        endChecked <= 1;
        check(pixQ.size() == 0, "R10", "pixels still missing", 512'(pixQ.size()), 512'(0));
        check(wordQ.size() == 0, "R10", "words not replayed", 512'(wordQ.size()), 512'(0));
      end
    end
  end

endmodule

module pix_pack_serdes_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drain = 1'b0;
  logic endPhase = 1'b0;
  int   chkU, failU, chkP, failP;
  bit   reported = 0;

  always #2 clk = ~clk;

  // unpacked lane: 3 x 10-bit components, 16-bit words
  pix_pack_serdes_lane #(.NUM_COMP(3), .COMP_W(10), .PACKED(1'b0)) laneU (
    .clk(clk), .rstN(rstN), .drain(drain), .endPhase(endPhase),
    .nChecks(chkU), .nFails(failU)
  );

  // packed lane: 3 x 10-bit components, 32-bit words
  pix_pack_serdes_lane #(.NUM_COMP(3), .COMP_W(10), .PACKED(1'b1)) laneP (
    .clk(clk), .rstN(rstN), .drain(drain), .endPhase(endPhase),
    .nChecks(chkP), .nFails(failP)
  );

  int extraChecks = 0, extraFails = 0;

  task automatic widthCheck(input bit ok, input string tag, input int act, input int exp);
    extraChecks++;
    if (!ok) begin
      extraFails++;
      $display("FAIL %s word width: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report(input int watchdogFail);
    int total, fails;
    if (!reported) begin
      reported = 1;
      total = chkU + chkP + extraChecks + watchdogFail;
      fails = failU + failP + extraFails + watchdogFail;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    widthCheck($bits(laneU.uut.wrData) == 16, "R3", $bits(laneU.uut.wrData), 16);
    widthCheck($bits(laneP.uut.wrData) == 32, "R1", $bits(laneP.uut.wrData), 32);
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1 rstN = 1'b1;
    repeat (4000) @(posedge clk);
    drain = 1'b1;
    repeat (300) @(posedge clk);
    endPhase = 1'b1;
    repeat (3) @(posedge clk);
    report(0);
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    report(1);
  end

endmodule